// File: doc/BRIEF.md
# Data Access Breakpoint and Alignment Checker

This block watches each data memory access on its way to the memory system. An access is a one-cycle strobe with a 32-bit address and a flag that marks it as a store or a load. First, the block may move the address into a process slot. When a process field has been programmed and the upper seven address bits are all zero, those bits are filled from that field. The relocated address appears at once on a combinational output. The block then checks it for word alignment and compares it against two debug address registers.

An alignment abort or a breakpoint hit is reported as a one-cycle pulse in the cycle after the strobe. An abort can capture a fault status code and the faulting address. A hit can record an entry-reason code in a debug status word. Both captures happen only when the enable bit at the top of that debug status word is set. Software loads the control word, the process field, both address registers and the debug status word through a single write port. The core that takes the resulting exception sits outside this block.

Top module: `dacc_checker`

## Requirements
- R1: After reset, `hit_o`, `abort_o`, `fault_status`, `fault_addr` and `dbg_status` are all zero, and the block holds no process field, no comparator enables and no alignment enable.
- R2: `wr_sel` 1 stores `wr_data[31:25]` as the process field. When that field is nonzero and `acc_addr[31:25]` is zero, `reloc_addr` is `acc_addr` with bits 31:25 replaced by the field. In every other case `reloc_addr` equals `acc_addr`.
- R3: When control bit 9 (alignment enable) is set and `reloc_addr[1:0]` is nonzero on a strobed access, `abort_o` pulses. When control bit 9 is clear, no abort is raised.
- R4: An abort loads `fault_status` with 1 and `fault_addr` with the relocated address, but only when `dbg_status[31]` is set. When that bit is clear, both registers keep their values.
- R5: Comparator 0 takes its direction field from control bits 1:0, with 0 = off, 1 = stores only, 2 = loads and stores, 3 = loads only.
- R6: Comparator 1 takes its direction field from control bits 3:2, uses the same encoding, and compares against address register 1 (`wr_sel` 3). Address register 0 is loaded with `wr_sel` 2.
- R7: In normal mode (control bit 8 clear), a comparator matches when `reloc_addr[31:2]` equals bits 31:2 of its register. Address bits 1:0 are ignored.
- R8: In mask mode (control bit 8 set), comparator 1 is off. Comparator 0 matches when the address equals address register 0 on every bit where address register 1 holds a zero.
- R9: Any match pulses `hit_o`, whatever `dbg_status[31]` holds. When `dbg_status[31]` is set, the hit also writes the code 3'b010 into `dbg_status[4:2]` and leaves the other bits unchanged. The control word is written with `wr_sel` 0 and the debug status word with `wr_sel` 4.
- R10: An access that both aborts and matches reports only the abort. It records no entry code.
- R11: `hit_o` and `abort_o` are high only in the single cycle after an access strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 control, 1 process field, 2 address 0, 3 address 1, 4 debug status |
| wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| acc_store | input | 1 | 1 = store, 0 = load |
| reloc_addr | output | 32 | Address after process relocation |
| hit_o | output | 1 | Breakpoint hit pulse |
| abort_o | output | 1 | Alignment abort pulse |
| fault_status | output | 32 | Captured fault status |
| fault_addr | output | 32 | Captured fault address |
| dbg_status | output | 32 | Debug status word including entry code |

## Verification
Each of the four direction codes is tried with both a load and a store to the same matching address. This separates store-only, load-only and both-direction decoding and catches swapped codes. Addresses with only the low two bits different from a register, or with one bit different above them, separate the normal word comparison from exact or coarser matching. In mask mode, one access differs only in bits that the mask ignores, one differs in a bit the mask keeps, and one would match register 1 under normal rules. Together they show that the mask polarity is right and that comparator 1 is switched off. Relocation is tried with a zero field, a full field and an address whose upper bits are already set. Misaligned accesses that also match a breakpoint show which report wins.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    // register select codes on the write port
    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_PID   = 3'd1,
        SEL_BASE0 = 3'd2,
        SEL_BASE1 = 3'd3,
        SEL_DSTAT = 3'd4
    } wsel_e;

    // per-comparator direction field
    typedef enum logic [1:0] {
        DIR_OFF   = 2'd0,
        DIR_STORE = 2'd1,
        DIR_BOTH  = 2'd2,
        DIR_LOAD  = 2'd3
    } dir_e;

    typedef struct packed {
        logic       align_en;
        logic       mask_mode;
        logic [1:0] dir1;
        logic [1:0] dir0;
    } ctrl_t;

    localparam int CTL_DIR0_LSB  = 0;
    localparam int CTL_DIR1_LSB  = 2;
    localparam int CTL_MASK_BIT  = 8;
    localparam int CTL_ALIGN_BIT = 9;

    localparam int       MOE_LSB  = 2;
    localparam int       MOE_W    = 3;
    localparam logic [2:0] MOE_DBRK = 3'b010;

    localparam logic [7:0] FAULT_ALIGN_CODE = 8'h01;

    function automatic logic dir_allows(logic [1:0] dir, logic is_store);
        case (dir_e'(dir))
            DIR_STORE: return is_store;
            DIR_LOAD:  return !is_store;
            DIR_BOTH:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dacc_reloc.sv
module dacc_reloc #(
    parameter int ADDR_W  = 32,
    parameter int PID_LSB = 25,
    localparam int PID_W  = ADDR_W - PID_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PID_W-1:0]  pid,
    output logic [ADDR_W-1:0] addr_out
);
    logic upper_clear;

    always_comb begin
        upper_clear = (addr[ADDR_W-1:PID_LSB] == '0);
        addr_out    = addr;
        if (upper_clear && (pid != '0))
            addr_out[ADDR_W-1:PID_LSB] = pid;
    end
endmodule

// File: rtl/dacc_cmp.sv
module dacc_cmp
    import dacc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] care,
    input  logic [1:0]        dir,
    input  logic              is_store,
    output logic              match
);
    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff  = (addr ^ base) & care;
        match = dir_allows(dir, is_store) && (diff == '0);
    end
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker
    import dacc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PID_LSB = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_store,
    output logic [ADDR_W-1:0] reloc_addr,
    output logic              hit_o,
    output logic              abort_o,
    output logic [ADDR_W-1:0] fault_status,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ADDR_W-1:0] dbg_status
);
    localparam int PID_W  = ADDR_W - PID_LSB;
    localparam int NCMP   = 2;
    localparam int DS_EN  = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] WORD_CARE = {{(ADDR_W-2){1'b1}}, 2'b00};
    localparam logic [ADDR_W-1:0] FAULT_WORD =
        {{(ADDR_W-8){1'b0}}, FAULT_ALIGN_CODE};

    ctrl_t             ctrl_q;
    logic [PID_W-1:0]  pid_q;
    logic [ADDR_W-1:0] base_q [NCMP];
    logic [ADDR_W-1:0] dstat_q, fstat_q, faddr_q;
    logic              hit_q, abort_q;

    logic [ADDR_W-1:0] addr_r;
    logic [ADDR_W-1:0] care   [NCMP];
    logic [1:0]        dir_eff[NCMP];
    logic [NCMP-1:0]   match;
    logic              misalign, any_match;

    dacc_reloc #(.ADDR_W(ADDR_W), .PID_LSB(PID_LSB)) u_reloc (
        .addr     (acc_addr),
        .pid      (pid_q),
        .addr_out (addr_r)
    );

    // comparator 0 may switch to masked matching, comparator 1 is then idle
    always_comb begin
        care[0]    = ctrl_q.mask_mode ? ~base_q[1] : WORD_CARE;
        care[1]    = WORD_CARE;
        dir_eff[0] = ctrl_q.dir0;
        dir_eff[1] = ctrl_q.mask_mode ? 2'b00 : ctrl_q.dir1;
    end

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        dacc_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .addr     (addr_r),
            .base     (base_q[k]),
            .care     (care[k]),
            .dir      (dir_eff[k]),
            .is_store (acc_store),
            .match    (match[k])
        );
    end

    always_comb begin
        misalign  = ctrl_q.align_en && (addr_r[1:0] != 2'b00);
        any_match = |match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            pid_q   <= '0;
            for (int i = 0; i < NCMP; i++) base_q[i] <= '0;
            dstat_q <= '0;
            fstat_q <= '0;
            faddr_q <= '0;
            hit_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            hit_q   <= 1'b0;
            abort_q <= 1'b0;
            if (acc_valid) begin
                if (misalign) begin
                    abort_q <= 1'b1;
                    if (dstat_q[DS_EN]) begin
                        fstat_q <= FAULT_WORD;
                        faddr_q <= addr_r;
                    end
                end else if (any_match) begin
                    hit_q <= 1'b1;
                    if (dstat_q[DS_EN])
                        dstat_q[MOE_LSB +: MOE_W] <= MOE_DBRK;
                end
            end
            // a register write in the same cycle takes precedence
            if (wr_en) begin
                case (wsel_e'(wr_sel))
                    SEL_CTRL: ctrl_q <= '{align_en:  wr_data[CTL_ALIGN_BIT],
                                          mask_mode: wr_data[CTL_MASK_BIT],
                                          dir1:      wr_data[CTL_DIR1_LSB +: 2],
                                          dir0:      wr_data[CTL_DIR0_LSB +: 2]};
                    SEL_PID:   pid_q     <= wr_data[ADDR_W-1:PID_LSB];
                    SEL_BASE0: base_q[0] <= wr_data;
                    SEL_BASE1: base_q[1] <= wr_data;
                    SEL_DSTAT: dstat_q   <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assign reloc_addr   = addr_r;
    assign hit_o        = hit_q;
    assign abort_o      = abort_q;
    assign fault_status = fstat_q;
    assign fault_addr   = faddr_q;
    assign dbg_status   = dstat_q;

endmodule

// File: rtl/dacc_checker_sva.sv
module dacc_checker_sva #(
    parameter int ADDR_W  = 32,
    parameter int PID_LSB = 25
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0] reloc_addr,
    input logic              hit_o,
    input logic              abort_o,
    input logic [ADDR_W-1:0] fault_status,
    input logic [ADDR_W-1:0] fault_addr,
    input logic [ADDR_W-1:0] dbg_status
);
    // R10: an abort and a hit never appear together
    a_r10_abort_over_hit: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> !hit_o);

    // R11: result pulses only follow a strobe
    a_r11_hit_after_strobe: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(acc_valid));

    a_r11_abort_after_strobe: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> $past(acc_valid));

    // R3: an abort comes from an address with nonzero low bits
    a_r3_abort_misaligned: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> ($past(reloc_addr[1:0]) != 2'b00));

    // R4: fault capture is gated by the debug enable bit
    a_r4_fault_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(dbg_status[ADDR_W-1]) |-> ($stable(fault_addr) && $stable(fault_status)));

    // R4: the fault address only moves together with an abort
    a_r4_fault_with_abort: assert property (@(posedge clk) disable iff (rst)
        (fault_addr != $past(fault_addr)) |-> abort_o);

    // R2: relocation never touches the bits below the process field
    a_r2_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (reloc_addr[PID_LSB-1:0] == acc_addr[PID_LSB-1:0]));
endmodule

bind dacc_checker dacc_checker_sva #(.ADDR_W(ADDR_W), .PID_LSB(PID_LSB)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .reloc_addr   (reloc_addr),
    .hit_o        (hit_o),
    .abort_o      (abort_o),
    .fault_status (fault_status),
    .fault_addr   (fault_addr),
    .dbg_status   (dbg_status)
);

// File: tb/sim_dacc_checker.sv
`timescale 1ns/1ps
module sim_dacc_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_store = 1'b0;
    logic [31:0] reloc_addr, fault_status, fault_addr, dbg_status;
    logic        hit_o, abort_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dacc_checker u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_store(acc_store),
        .reloc_addr(reloc_addr), .hit_o(hit_o), .abort_o(abort_o),
        .fault_status(fault_status), .fault_addr(fault_addr), .dbg_status(dbg_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive one access; outputs are sampled on the following falling edge
    task automatic access(input logic [31:0] addr, input logic st);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = addr; acc_store = st;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 hit", {31'b0, hit_o}, 32'd0);
        check("R1 abort", {31'b0, abort_o}, 32'd0);
        check("R1 fault_status", fault_status, 32'd0);
        check("R1 fault_addr", fault_addr, 32'd0);
        check("R1 dbg_status", dbg_status, 32'd0);
        access(32'h0000_1001, 1'b1);
        check("R1 no abort after reset", {31'b0, abort_o}, 32'd0);
        check("R1 no hit after reset", {31'b0, hit_o}, 32'd0);
    endtask

    task automatic t_reloc;
        wr(3'd1, 32'h1400_0000);
        @(negedge clk); acc_addr = 32'h0000_1234; #1;
        check("R2 relocate", reloc_addr, 32'h1400_1234);
        acc_addr = 32'h0200_0010; #1;
        check("R2 upper set kept", reloc_addr, 32'h0200_0010);
        wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk); acc_addr = 32'h0000_0010; #1;
        check("R2 full field", reloc_addr, 32'hFE00_0010);
        wr(3'd1, 32'h0000_0000);
        @(negedge clk); acc_addr = 32'h0000_1234; #1;
        check("R2 zero field", reloc_addr, 32'h0000_1234);
    endtask

    task automatic t_align;
        wr(3'd4, 32'h8000_0000);
        wr(3'd0, 32'h0000_0200);
        wr(3'd1, 32'h1400_0000);
        access(32'h0000_0102, 1'b1);
        check("R3 abort", {31'b0, abort_o}, 32'd1);
        check("R4 fault_status", fault_status, 32'h0000_0001);
        check("R4 fault_addr relocated", fault_addr, 32'h1400_0102);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0);
        access(32'h0000_0203, 1'b0);
        check("R3 disabled no abort", {31'b0, abort_o}, 32'd0);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h0000_0200);
        access(32'h0000_0301, 1'b0);
        check("R4 abort without capture", {31'b0, abort_o}, 32'd1);
        check("R4 fault_addr held", fault_addr, 32'h1400_0102);
        check("R4 fault_status held", fault_status, 32'h0000_0001);
    endtask

    task automatic t_dir0;
        wr(3'd2, 32'h0000_1000);
        for (int d = 0; d < 4; d++) begin
            wr(3'd0, d);
            for (int s = 0; s < 2; s++) begin
                logic exp;
                exp = (d == 1) ? (s == 1) : (d == 3) ? (s == 0) : (d == 2);
                access(32'h0000_1000, s[0]);
                check($sformatf("R5 dir %0d store %0d", d, s), {31'b0, hit_o}, {31'b0, exp});
            end
        end
    endtask

    task automatic t_cmp1;
        wr(3'd3, 32'h0000_2000);
        wr(3'd0, 32'h0000_0008);
        access(32'h0000_2000, 1'b0);
        check("R6 comparator 1 hit", {31'b0, hit_o}, 32'd1);
        access(32'h0000_1000, 1'b0);
        check("R6 comparator 0 off", {31'b0, hit_o}, 32'd0);
        access(32'h0000_2003, 1'b1);
        check("R7 low bits ignored", {31'b0, hit_o}, 32'd1);
        access(32'h0000_2004, 1'b1);
        check("R7 bit 2 compared", {31'b0, hit_o}, 32'd0);
    endtask

    task automatic t_mask;
        wr(3'd2, 32'h8000_0000);
        wr(3'd3, 32'h0000_FFFF);
        wr(3'd0, 32'h0000_010A);
        access(32'h8000_1234, 1'b1);
        check("R8 masked bits ignored", {31'b0, hit_o}, 32'd1);
        access(32'h8001_0000, 1'b1);
        check("R8 kept bit compared", {31'b0, hit_o}, 32'd0);
        access(32'h0000_FFFC, 1'b0);
        check("R8 comparator 1 off", {31'b0, hit_o}, 32'd0);
    endtask

    task automatic t_moe;
        wr(3'd2, 32'h0000_1000);
        wr(3'd0, 32'h0000_0002);
        wr(3'd4, 32'h8000_0000);
        access(32'h0000_1000, 1'b0);
        check("R9 hit", {31'b0, hit_o}, 32'd1);
        check("R9 entry code", dbg_status, 32'h8000_0008);
        @(negedge clk);
        check("R11 hit is one cycle", {31'b0, hit_o}, 32'd0);
        wr(3'd4, 32'h0000_0000);
        access(32'h0000_1000, 1'b1);
        check("R9 hit without enable", {31'b0, hit_o}, 32'd1);
        check("R9 no code without enable", dbg_status, 32'h0000_0000);
    endtask

    task automatic t_prio;
        wr(3'd0, 32'h0000_0202);
        wr(3'd4, 32'h8000_0000);
        access(32'h0000_1001, 1'b0);
        check("R10 abort wins", {31'b0, abort_o}, 32'd1);
        check("R10 no hit", {31'b0, hit_o}, 32'd0);
        check("R10 no entry code", dbg_status, 32'h8000_0000);
        check("R10 fault_addr", fault_addr, 32'h0000_1001);
        @(negedge clk);
        check("R11 abort is one cycle", {31'b0, abort_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reloc();
        t_align();
        t_dir0();
        t_cmp1();
        t_mask();
        t_moe();
        t_prio();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule